// File: doc/BRIEF.md
# Ethernet Transmit Pad and FCS Inserter

This block sits in the transmit byte path, between the host-side transmit FIFO and the MAC serializer. Frame bytes arrive on a valid/ready stream, and the final byte of each frame is marked. Each byte is forwarded in the same cycle it is accepted. When the frame ends, the block can append zero pad bytes so that a short frame reaches the minimum Ethernet size. It then appends a 4-byte CRC-32 frame check sequence. The output is a byte stream with valid, last and ready.

Two control bits decide what is appended: auto-pad and FCS-disable. They live in a small control register, written through `ctl_we_i`. The frame uses the values the register holds on the cycle its end-of-frame byte is accepted. Earlier writes in the frame take effect. Writes after that byte wait for the next frame. Auto-pad wins over FCS-disable, and the CRC covers the pad bytes.

Top module: `eth_tx_pad_fcs`

## Requirements
- R1: In the data phase, every byte accepted on the input appears on the output in the same cycle, unchanged and in order. `in_ready_o` equals `out_ready_i` in this phase.
- R2: Auto-pad active and N < 60 data bytes: exactly 60−N bytes of value 0x00 follow the data, then the 4 FCS bytes, for 64 bytes in total.
- R3: Auto-pad active and N ≥ 60 data bytes: no pad is added, and the frame is N data bytes plus 4 FCS bytes.
- R4: The FCS is the reflected CRC-32 (reflected polynomial 0xEDB88320, preset all ones) over all data and pad bytes, taking each byte's bit 0 first. The complemented result is sent least significant byte first. Every frame starts again from the preset.
- R5: Auto-pad active overrides FCS-disable, so the FCS is still appended.
- R6: Auto-pad off and FCS-disable set: only the N data bytes go out, and `out_last_o` is on the last data byte.
- R7: Auto-pad off and FCS-disable clear: N data bytes plus the FCS, with no pad even when N < 60.
- R8: The frame uses the control values held on the cycle its end-of-frame byte is accepted. A register write (`ctl_we_i`) before that cycle applies to the frame. A write after that cycle does not change the frame's tail.
- R9: After reset the control register holds auto-pad = 1 and FCS-disable = 0, `out_valid_o` is low while no input is valid, and `in_ready_o` follows `out_ready_i`.
- R10: `in_ready_o` stays low while pad or FCS bytes are being emitted.
- R11: While `out_ready_i` is low, a pending pad or FCS byte holds its value with valid high, and no byte is lost or repeated.
- R12: `out_last_o` is set on exactly one byte per frame: the final byte emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Write strobe for the control register |
| ctl_auto_pad_i | input | 1 | Auto-pad value written on `ctl_we_i` |
| ctl_no_fcs_i | input | 1 | FCS-disable value written on `ctl_we_i` |
| in_data_i | input | 8 | Input frame byte |
| in_valid_i | input | 1 | Input byte valid |
| in_last_i | input | 1 | Input byte is the end of frame |
| in_ready_o | output | 1 | Block accepts an input byte |
| out_data_o | output | 8 | Output byte |
| out_valid_o | output | 1 | Output byte valid |
| out_last_o | output | 1 | Output byte is the last of the frame |
| out_ready_i | input | 1 | Downstream accepts the output byte |

## Verification
The assertions assume that an upstream source holds `in_valid_i` and the input byte steady until accepted. They also assume that every frame ends with a marked byte. The bench keeps to this by driving each byte until it sees `in_ready_o` high before the edge, and by always closing a frame with `in_last_i`. The pad-length and hold properties assume a downstream that eventually raises `out_ready_i`. The bench's ready patterns never hold it low for more than a few cycles.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [1:0] {
    ST_DATA = 2'd0,
    ST_PAD  = 2'd1,
    ST_FCS  = 2'd2
  } tx_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET    = 32'hFFFFFFFF;

  // one byte through the reflected CRC, bit 0 first
  function automatic logic [31:0] crc_byte_step(input logic [31:0] crc, input logic [7:0] d);
    logic [31:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/eth_tx_crc32.sv
module eth_tx_crc32
  import eth_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clear_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_PRESET;
    else if (clear_i) crc_q <= CRC_PRESET;
    else if (en_i)    crc_q <= crc_byte_step(crc_q, byte_i);
  end

  assign crc_o = crc_q;

  AST_CRC_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (crc_q == CRC_PRESET)); // R4

endmodule

// File: rtl/eth_tx_len_ctr.sv
module eth_tx_len_ctr #(
  parameter int unsigned MAX_COUNT = 60,
  localparam int unsigned CNT_W   = $clog2(MAX_COUNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  logic [CNT_W-1:0] cnt_q;

  // saturates: only "reached minimum" matters past MAX_COUNT
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (clear_i)                              cnt_q <= '0;
    else if (inc_i && cnt_q < CNT_W'(MAX_COUNT))   cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_COUNT)); // R3

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_pkg::*;
#(
  parameter int unsigned MIN_PAYLOAD = 60,
  parameter int unsigned FCS_BYTES   = 4,
  localparam int unsigned CNT_W      = $clog2(MIN_PAYLOAD + 1),
  localparam int unsigned IDX_W      = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             in_last_i,
  input  logic             auto_pad_i,
  input  logic             no_fcs_i,
  input  logic [CNT_W-1:0] count_i,
  output tx_state_e        state_o,
  output logic [IDX_W-1:0] fcs_idx_o
);

  tx_state_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             near_min;
  logic             idx_end;

  // count_i holds bytes before the current one
  assign near_min = count_i >= CNT_W'(MIN_PAYLOAD - 1);
  assign idx_end  = idx_q == IDX_W'(FCS_BYTES - 1);

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_DATA: if (fire_i && in_last_i) begin
        if (auto_pad_i && !near_min)    st_d = ST_PAD;
        else if (auto_pad_i || !no_fcs_i) st_d = ST_FCS;
      end
      ST_PAD: if (fire_i && near_min) st_d = ST_FCS;
      ST_FCS: if (fire_i) begin
        if (idx_end) begin
          st_d  = ST_DATA;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_DATA;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign state_o   = st_q;
  assign fcs_idx_o = idx_q;

  AST_IDX_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_FCS) |-> (idx_q == '0)); // R4

  AST_FCS_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FCS && fire_i && idx_end) |=> (st_q == ST_DATA)); // R12

endmodule

// File: rtl/eth_tx_pad_fcs.sv
module eth_tx_pad_fcs
  import eth_tx_pkg::*;
#(
  parameter int unsigned MIN_FRAME = 64,
  parameter int unsigned FCS_BYTES = 4,
  localparam int unsigned MIN_PAYLOAD = MIN_FRAME - FCS_BYTES,
  localparam int unsigned CNT_W       = $clog2(MIN_PAYLOAD + 1),
  localparam int unsigned IDX_W       = (FCS_BYTES > 1) ? $clog2(FCS_BYTES) : 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctl_we_i,
  input  logic       ctl_auto_pad_i,
  input  logic       ctl_no_fcs_i,
  input  logic [7:0] in_data_i,
  input  logic       in_valid_i,
  input  logic       in_last_i,
  output logic       in_ready_o,
  output logic [7:0] out_data_o,
  output logic       out_valid_o,
  output logic       out_last_o,
  input  logic       out_ready_i
);

  logic             auto_pad_q, no_fcs_q;
  tx_state_e        st;
  logic [IDX_W-1:0] fcs_idx;
  logic [CNT_W-1:0] count;
  logic [31:0]      crc;
  logic             fire, frame_done, body_fire;

  // control register; frame uses value held at its EOF beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      auto_pad_q <= 1'b1;
      no_fcs_q   <= 1'b0;
    end else if (ctl_we_i) begin
      auto_pad_q <= ctl_auto_pad_i;
      no_fcs_q   <= ctl_no_fcs_i;
    end
  end

  always_comb begin
    in_ready_o  = 1'b0;
    out_valid_o = 1'b1;
    out_data_o  = 8'h00;
    out_last_o  = 1'b0;
    unique case (st)
      ST_DATA: begin
        in_ready_o  = out_ready_i;
        out_valid_o = in_valid_i;
        out_data_o  = in_data_i;
        out_last_o  = in_last_i && !auto_pad_q && no_fcs_q;
      end
      ST_PAD: ;
      ST_FCS: begin
        out_data_o = ~crc[{fcs_idx, 3'b000} +: 8];
        out_last_o = fcs_idx == IDX_W'(FCS_BYTES - 1);
      end
      default: out_valid_o = 1'b0;
    endcase
  end

  assign fire       = out_valid_o && out_ready_i;
  assign frame_done = fire && out_last_o;
  assign body_fire  = fire && (st != ST_FCS);

  eth_tx_seq #(
    .MIN_PAYLOAD (MIN_PAYLOAD),
    .FCS_BYTES   (FCS_BYTES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .in_last_i  (in_last_i),
    .auto_pad_i (auto_pad_q),
    .no_fcs_i   (no_fcs_q),
    .count_i    (count),
    .state_o    (st),
    .fcs_idx_o  (fcs_idx)
  );

  eth_tx_len_ctr #(
    .MAX_COUNT (MIN_PAYLOAD)
  ) u_len (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (frame_done),
    .inc_i   (body_fire),
    .count_o (count)
  );

  eth_tx_crc32 u_crc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (frame_done),
    .en_i    (body_fire),
    .byte_i  (out_data_o),
    .crc_o   (crc)
  );

  AST_PAD_BELOW_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PAD) |-> (count < CNT_W'(MIN_PAYLOAD))); // R2

  AST_TAIL_BLOCKS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_DATA) |-> !in_ready_o); // R10

  AST_TAIL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_DATA && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(st))); // R11

  AST_FCS_REACHES_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(st == ST_FCS) && $past(st) == ST_PAD) |-> (count == CNT_W'(MIN_PAYLOAD))); // R2

endmodule

// File: tb/eth_tx_pad_fcs_bench.sv
module eth_tx_pad_fcs_bench;

  localparam int MIN_PAY = 60;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_we_i = 1'b0, ctl_auto_pad_i = 1'b0, ctl_no_fcs_i = 1'b0;
  logic [7:0] in_data_i = 8'h00;
  logic       in_valid_i = 1'b0, in_last_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] out_data_o;
  logic       out_valid_o, out_last_o;
  logic       out_ready_i = 1'b1;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  bit   got_done = 0;
  bit   tail_active = 0;
  int   tail_ready_hits = 0;
  int   bp_mode = 0;
  int   cyc = 0;

  always #2.5 clk_i = ~clk_i;

  eth_tx_pad_fcs u_eth_tx_pad_fcs (
    .clk_i, .rst_ni, .ctl_we_i, .ctl_auto_pad_i, .ctl_no_fcs_i,
    .in_data_i, .in_valid_i, .in_last_i, .in_ready_o,
    .out_data_o, .out_valid_o, .out_last_o, .out_ready_i
  );

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run hung, got %0d expected completion", cyc);
    finish_run();
  end

  // ready pattern, driven just after the edge
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    #1;
    if (bp_mode == 0) out_ready_i = 1'b1;
    else              out_ready_i = ((cyc * 7 + bp_mode) % 5) != 0;
  end

  // output capture away from the edge
  always @(negedge clk_i) begin
    if (tail_active && in_ready_o) tail_ready_hits++;
    if (rst_ni && out_valid_o && out_ready_i && !got_done) begin
      got_q.push_back(out_data_o);
      if (out_last_o) begin
        got_done = 1;
        tail_active = 0;
      end
    end
  end

  function automatic logic [31:0] ref_fcs(input logic [7:0] q[$]);
    logic [31:0] c, r, rv;
    c = 32'hFFFFFFFF;
    foreach (q[k]) begin
      for (int j = 0; j < 8; j++) begin
        if (c[31] ^ q[k][j]) c = {c[30:0], 1'b0} ^ 32'h04C11DB7;
        else                 c = {c[30:0], 1'b0};
      end
    end
    r = ~c;
    for (int b = 0; b < 32; b++) rv[b] = r[31 - b];
    return rv;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic ctl_write(input bit ap, input bit nf);
    ctl_we_i = 1; ctl_auto_pad_i = ap; ctl_no_fcs_i = nf;
    @(posedge clk_i); #1;
    ctl_we_i = 0;
  endtask

  // eff_ap/eff_nf: values the frame must use; mid_at: index of byte carrying a ctl write
  task automatic send_frame(input int n, input int seed, input bit eff_ap, input bit eff_nf,
                            input int mid_at, input bit mid_ap, input bit mid_nf,
                            input bit post_wr, input bit post_ap, input bit post_nf,
                            input string req);
    logic [31:0] f;
    bit acc;
    exp_q.delete(); got_q.delete();
    got_done = 0; tail_ready_hits = 0;
    for (int i = 0; i < n; i++) exp_q.push_back(8'((i * 37 + seed * 11 + (i >> 3)) ^ seed));
    if (eff_ap) while (exp_q.size() < MIN_PAY) exp_q.push_back(8'h00);
    if (eff_ap || !eff_nf) begin
      f = ref_fcs(exp_q);
      for (int b = 0; b < 4; b++) exp_q.push_back(f[8*b +: 8]);
    end
    for (int i = 0; i < n; i++) begin
      in_valid_i = 1;
      in_data_i  = 8'((i * 37 + seed * 11 + (i >> 3)) ^ seed);
      in_last_i  = (i == n - 1);
      ctl_we_i = (i == mid_at); ctl_auto_pad_i = mid_ap; ctl_no_fcs_i = mid_nf;
      do begin
        @(negedge clk_i); acc = in_ready_o;
        @(posedge clk_i); #1;
        ctl_we_i = 0;
      end while (!acc);
    end
    in_valid_i = 0; in_last_i = 0;
    if (exp_q.size() > n) tail_active = 1;
    if (post_wr) ctl_write(post_ap, post_nf);
    while (!got_done) begin @(posedge clk_i); #1; end
    check(got_q.size() == exp_q.size(), req, $sformatf("len n=%0d ap=%0d nf=%0d", n, eff_ap, eff_nf),
          got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size()) begin
      int bad = -1;
      foreach (exp_q[k]) if (bad < 0 && got_q[k] !== exp_q[k]) bad = k;
      check(bad < 0, req, $sformatf("byte %0d n=%0d", bad, n),
            bad < 0 ? 0 : int'(got_q[bad]), bad < 0 ? 0 : int'(exp_q[bad]));
    end
    if (exp_q.size() > n)
      check(tail_ready_hits == 0, "R10", "in_ready high cycles in tail", tail_ready_hits, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    @(negedge clk_i);
    check(out_valid_o == 0, "R9", "out_valid after reset", out_valid_o, 0);
    check(in_ready_o == out_ready_i, "R9", "in_ready follows out_ready", in_ready_o, out_ready_i);
    @(posedge clk_i); #1;
    // R9: default register gives auto-pad with FCS
    send_frame(5, 3, 1, 0, -1, 0, 0, 0, 0, 0, "R9");

    // sweep R1 R2 R3 R4 R5 R6 R7 R11 R12 over lengths and control combinations
    for (int cfg = 0; cfg < 4; cfg++) begin
      bit ap = cfg[1], nf = cfg[0];
      string rq = ap ? (nf ? "R5" : "R2/R3/R4") : (nf ? "R6" : "R7");
      ctl_write(ap, nf);
      for (int n = 1; n <= 70; n++) begin
        bp_mode = (n % 3 == 0) ? (n % 4) + 1 : 0; // R11 backpressure on every third frame
        send_frame(n, n + cfg * 71, ap, nf, -1, 0, 0, 0, 0, 0, rq);
      end
    end
    bp_mode = 0;

    // R8: write mid-frame before EOF applies to this frame
    ctl_write(0, 1);
    send_frame(10, 5, 1, 0, 4, 1, 0, 0, 0, 0, "R8");
    // R8: write on the EOF beat itself does not apply to this frame
    send_frame(12, 6, 1, 0, 11, 0, 1, 0, 0, 0, "R8");
    // register now ap=0 nf=1; a write after EOF does not alter this frame
    send_frame(8, 7, 0, 1, -1, 0, 0, 1, 1, 0, "R8");
    // R8: a write during the pad phase leaves that frame padded
    send_frame(10, 8, 1, 0, -1, 0, 0, 1, 0, 1, "R8");
    send_frame(10, 9, 0, 1, -1, 0, 0, 0, 0, 0, "R8");
    // R3 boundary at exactly 59/60 with backpressure
    ctl_write(1, 1);
    bp_mode = 2;
    send_frame(59, 10, 1, 1, -1, 0, 0, 0, 0, 0, "R2");
    send_frame(60, 11, 1, 1, -1, 0, 0, 0, 0, 0, "R3");
    bp_mode = 0;
    finish_run();
  end

endmodule